// File: doc/BRIEF.md
# SDRAM Byte-Lane Data Mask Pipeline

This block turns the per-byte data mask of a 16-bit SDRAM data bus into two sets of lane controls. During writes, the mask is applied in the same cycle: a lane whose mask is low gets its write enable, and a lane whose mask is high is blocked. During reads, the mask works as a delayed output enable. A mask value sampled at one rising edge governs the read data presented two edges later. The controller that owns the pad drivers uses these enables directly. Burst counting and CAS-latency data timing are handled by neighbouring logic. That logic supplies the read-burst-active and write-burst-active flags.

Internally, each lane keeps a read shift register `READ_LAT` stages deep, which holds a valid bit and a mask bit per stage. A small bus-mode state machine decides when that register needs to shift. Its states are:

- BUS_IDLE: nothing in flight, so the register is frozen.
- BUS_READ: a read sample is being pushed.
- BUS_WRITE: a write cycle; an empty slot is pushed.
- BUS_DRAIN: the flags have dropped, and the register keeps shifting for `READ_LAT-1` cycles until it is empty.

Its transitions are:

- go_write: any state moves to BUS_WRITE whenever the write flag is high.
- go_read: any state moves to BUS_READ when the read flag alone is high.
- burst_end: BUS_READ or BUS_WRITE moves to BUS_DRAIN when both flags are low.
- drain_done: BUS_DRAIN moves to BUS_IDLE when its countdown reaches one.
- idle_hold: BUS_IDLE stays in BUS_IDLE while both flags are low.

Top module: `sdram_lane_mask`

## Requirements
- R1: Mask bit 0 and enable bit 0 belong to the lower byte lane (DQ0–DQ7). Mask bit 1 and enable bit 1 belong to the upper byte lane (DQ8–DQ15). A mask of 2'b01 during a write yields write enables of 2'b10, and a mask of 2'b10 yields 2'b01.
- R2: While the write flag is high, a lane whose mask is low has its write enable at 1 in that same cycle, with no register in between.
- R3: While the write flag is high, a lane whose mask is high has its write enable at 0.
- R4: The mask is sampled at rising edge N while the read flag is high and the write flag is low. From edge N+1 to edge N+2, rd_oe_o for that lane is 1 if the mask was low and 0 if it was high. This window governs the data driven at edge N+2.
- R5: A mask sampled in the last read cycle still sets rd_oe_o at its normal latency, even when the read flag is low by then.
- R6: With the write flag low, write enables are 0. rd_oe_o is 0 when the sample taken two edges earlier was not a read.
- R7: While the write flag is high, rd_oe_o is 0 for both lanes. A sample taken while both flags are high counts as no read.
- R8: A synchronous active-high reset empties the read pipeline, so rd_oe_o is 0 after any edge with reset high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all sampling on the rising edge |
| rst | input | 1 | Synchronous reset, active high |
| lane_mask_i | input | NUM_LANES | Data mask per byte lane, high = masked |
| rd_burst_i | input | 1 | Read burst active |
| wr_burst_i | input | 1 | Write burst active |
| rd_oe_o | output | NUM_LANES | Read output enable per lane, aligned to read data |
| wr_be_o | output | NUM_LANES | Write byte enable per lane |

## Verification
The bench builds the block with its defaults: two lanes and a read latency of two. This makes every mask combination reachable, and each one is checked for lane order. A random mix of reads, writes and idle cycles drives the design. It is checked against a bench-side model of the two-stage delay. The mix includes bursts that stop one cycle after a masked read, reads followed directly by writes, and overlapping flags. Directed steps cover the drain after the last read cycle and a reset issued while a read is still in the pipeline.

// File: rtl/lane_mask_pkg.sv
package lane_mask_pkg;

    typedef enum logic [1:0] {
        BUS_IDLE  = 2'd0,
        BUS_READ  = 2'd1,
        BUS_WRITE = 2'd2,
        BUS_DRAIN = 2'd3
    } bus_mode_e;

endpackage

// File: rtl/lane_mask_fsm.sv
module lane_mask_fsm
    import lane_mask_pkg::*;
#(
    parameter int READ_LAT = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic rd_burst,
    input  logic wr_burst,
    output logic shift_en,
    output logic push_valid
);
    localparam int CNT_W = (READ_LAT > 2) ? $clog2(READ_LAT) : 1;
    localparam logic [CNT_W-1:0] DRAIN_LEN = CNT_W'(READ_LAT - 1);

    bus_mode_e        state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;

    // next-state logic
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            BUS_IDLE, BUS_READ, BUS_WRITE: begin
                if (wr_burst) begin
                    state_d = BUS_WRITE;
                end else if (rd_burst) begin
                    state_d = BUS_READ;
                end else if (state_q != BUS_IDLE) begin
                    state_d = BUS_DRAIN;
                    cnt_d   = DRAIN_LEN;
                end
            end
            BUS_DRAIN: begin
                if (wr_burst) begin
                    state_d = BUS_WRITE;
                end else if (rd_burst) begin
                    state_d = BUS_READ;
                end else if (cnt_q <= CNT_W'(1)) begin
                    state_d = BUS_IDLE;
                end else begin
                    cnt_d = cnt_q - CNT_W'(1);
                end
            end
            default: state_d = BUS_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= BUS_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // outputs
    always_comb begin
        shift_en   = rd_burst | wr_burst | (state_q != BUS_IDLE);
        push_valid = rd_burst & ~wr_burst;
    end

endmodule

// File: rtl/lane_mask_rdpipe.sv
module lane_mask_rdpipe #(
    parameter int NUM_LANES = 2,
    parameter int READ_LAT  = 2
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 shift_en,
    input  logic                 push_valid,
    input  logic [NUM_LANES-1:0] mask,
    output logic [NUM_LANES-1:0] lane_oe
);
    localparam int LAST = READ_LAT - 1;

    for (genvar l = 0; l < NUM_LANES; l++) begin : g_lane
        logic [READ_LAT-1:0] vld_q;
        logic [READ_LAT-1:0] msk_q;

        always_ff @(posedge clk) begin
            if (rst) begin
                vld_q <= '0;
                msk_q <= '1;
            end else if (shift_en) begin
                vld_q[0] <= push_valid;
                msk_q[0] <= mask[l];
                for (int s = 1; s < READ_LAT; s++) begin
                    vld_q[s] <= vld_q[s-1];
                    msk_q[s] <= msk_q[s-1];
                end
            end
        end

        assign lane_oe[l] = vld_q[LAST] & ~msk_q[LAST];
    end

endmodule

// File: rtl/lane_mask_wrgate.sv
module lane_mask_wrgate #(
    parameter int NUM_LANES = 2
) (
    input  logic                 wr_burst,
    input  logic [NUM_LANES-1:0] mask,
    output logic [NUM_LANES-1:0] lane_we
);
    for (genvar l = 0; l < NUM_LANES; l++) begin : g_lane
        assign lane_we[l] = wr_burst & ~mask[l];
    end
endmodule

// File: rtl/sdram_lane_mask.sv
module sdram_lane_mask #(
    parameter int NUM_LANES = 2,
    parameter int READ_LAT  = 2
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [NUM_LANES-1:0] lane_mask_i,
    input  logic                 rd_burst_i,
    input  logic                 wr_burst_i,
    output logic [NUM_LANES-1:0] rd_oe_o,
    output logic [NUM_LANES-1:0] wr_be_o
);
    logic                 shift_en;
    logic                 push_valid;
    logic [NUM_LANES-1:0] pipe_oe;

    lane_mask_fsm #(.READ_LAT(READ_LAT)) u_fsm (
        .clk        (clk),
        .rst        (rst),
        .rd_burst   (rd_burst_i),
        .wr_burst   (wr_burst_i),
        .shift_en   (shift_en),
        .push_valid (push_valid)
    );

    lane_mask_rdpipe #(.NUM_LANES(NUM_LANES), .READ_LAT(READ_LAT)) u_rdpipe (
        .clk        (clk),
        .rst        (rst),
        .shift_en   (shift_en),
        .push_valid (push_valid),
        .mask       (lane_mask_i),
        .lane_oe    (pipe_oe)
    );

    lane_mask_wrgate #(.NUM_LANES(NUM_LANES)) u_wrgate (
        .wr_burst (wr_burst_i),
        .mask     (lane_mask_i),
        .lane_we  (wr_be_o)
    );

    assign rd_oe_o = pipe_oe & {NUM_LANES{~wr_burst_i}};

endmodule

// File: rtl/lane_mask_chk.sv
module lane_mask_chk #(
    parameter int NUM_LANES = 2,
    parameter int READ_LAT  = 2
) (
    input logic                 clk,
    input logic                 rst,
    input logic [NUM_LANES-1:0] lane_mask_i,
    input logic                 rd_burst_i,
    input logic                 wr_burst_i,
    input logic [NUM_LANES-1:0] rd_oe_o,
    input logic [NUM_LANES-1:0] wr_be_o
);
    logic [1:0] warm_q;
    always_ff @(posedge clk) begin
        if (rst)                warm_q <= '0;
        else if (warm_q != 2'd3) warm_q <= warm_q + 2'd1;
    end

    // R2
    wr_open_chk: assert property (@(posedge clk) disable iff (rst)
        wr_burst_i |-> ((wr_be_o | lane_mask_i) == {NUM_LANES{1'b1}}));

    // R3
    wr_block_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_be_o & lane_mask_i) == '0);

    // R6
    wr_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !wr_burst_i |-> (wr_be_o == '0));

    // R7
    rd_off_in_write_chk: assert property (@(posedge clk) disable iff (rst)
        wr_burst_i |-> (rd_oe_o == '0));

    // R8
    rd_reset_clear_chk: assert property (@(posedge clk)
        rst |=> (wr_burst_i || rd_oe_o == '0));

    if (READ_LAT == 2) begin : g_lat2
        // R4
        rd_latency_chk: assert property (@(posedge clk) disable iff (rst || warm_q < 2'd2)
            !wr_burst_i |-> (rd_oe_o ==
                (($past(rd_burst_i & ~wr_burst_i, 2)) ? ~$past(lane_mask_i, 2) : '0)));
    end

endmodule

bind sdram_lane_mask lane_mask_chk #(.NUM_LANES(NUM_LANES), .READ_LAT(READ_LAT)) u_lane_mask_chk (
    .clk         (clk),
    .rst         (rst),
    .lane_mask_i (lane_mask_i),
    .rd_burst_i  (rd_burst_i),
    .wr_burst_i  (wr_burst_i),
    .rd_oe_o     (rd_oe_o),
    .wr_be_o     (wr_be_o)
);

// File: tb/test_sdram_lane_mask.sv
module test_sdram_lane_mask;
    localparam int CLK_PERIOD = 10;
    localparam int LANES      = 2;
    localparam int LAT        = 2;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic [LANES-1:0] mask = '0;
    logic             rd = 1'b0;
    logic             wr = 1'b0;
    logic [LANES-1:0] rd_oe;
    logic [LANES-1:0] wr_be;

    int checks = 0;
    int errors = 0;

    logic             mv [LAT];
    logic [LANES-1:0] mm [LAT];

    always #(CLK_PERIOD/2) clk = ~clk;

    sdram_lane_mask #(.NUM_LANES(LANES), .READ_LAT(LAT)) i_sdram_lane_mask (
        .clk(clk), .rst(rst), .lane_mask_i(mask), .rd_burst_i(rd),
        .wr_burst_i(wr), .rd_oe_o(rd_oe), .wr_be_o(wr_be)
    );

    function automatic logic [LANES-1:0] exp_be(logic w, logic [LANES-1:0] m);
        return w ? ~m : '0;
    endfunction

    function automatic logic [LANES-1:0] exp_oe(logic w, logic v, logic [LANES-1:0] m);
        return (!w && v) ? ~m : '0;
    endfunction

    task automatic check(string req, logic [LANES-1:0] act, logic [LANES-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic model_clear();
        for (int i = 0; i < LAT; i++) begin
            mv[i] = 1'b0;
            mm[i] = '1;
        end
    endtask

    // Called at a falling edge: apply inputs, check, then advance one clock.
    task automatic step(logic [LANES-1:0] m, logic r, logic w, logic rs);
        string tag_be, tag_oe;
        mask = m; rd = r; wr = w; rst = rs;
        #1;
        if (rs)                      tag_be = "R8";
        else if (!w)                 tag_be = "R6";
        else if (m == '0)            tag_be = "R2";
        else if (m == '1)            tag_be = "R3";
        else                         tag_be = "R1";
        if (w)                       tag_oe = "R7";
        else if (mv[LAT-1] && !r)    tag_oe = "R5";
        else if (mv[LAT-1])          tag_oe = "R4";
        else                         tag_oe = "R6";
        check(tag_be, wr_be, exp_be(w, m));
        check(tag_oe, rd_oe, exp_oe(w, mv[LAT-1], mm[LAT-1]));
        @(posedge clk);
        if (rs) begin
            model_clear();
        end else begin
            for (int s = LAT-1; s > 0; s--) begin
                mv[s] = mv[s-1];
                mm[s] = mm[s-1];
            end
            mv[0] = r & ~w;
            mm[0] = m;
        end
        @(negedge clk);
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        int seed;
        seed = 32'h5eed_2a17;
        void'($urandom(seed));
        model_clear();
        @(negedge clk);
        // R8: reset state
        step('0, 1'b0, 1'b0, 1'b1);
        step('0, 1'b0, 1'b0, 1'b1);
        check("R8", rd_oe, '0);
        // R1/R2/R3: each mask combination during writes
        step(2'b00, 1'b0, 1'b1, 1'b0);
        step(2'b01, 1'b0, 1'b1, 1'b0);
        step(2'b10, 1'b0, 1'b1, 1'b0);
        step(2'b11, 1'b0, 1'b1, 1'b0);
        // R4/R5: read with lane pattern, then flag drops
        step(2'b01, 1'b1, 1'b0, 1'b0);
        step(2'b10, 1'b1, 1'b0, 1'b0);
        step(2'b00, 1'b0, 1'b0, 1'b0);
        step(2'b11, 1'b0, 1'b0, 1'b0);
        step(2'b00, 1'b0, 1'b0, 1'b0);
        // R7: read immediately followed by write, and overlapping flags
        step(2'b00, 1'b1, 1'b0, 1'b0);
        step(2'b00, 1'b1, 1'b1, 1'b0);
        step(2'b00, 1'b0, 1'b0, 1'b0);
        step(2'b00, 1'b0, 1'b0, 1'b0);
        // R8: reset while a read is in flight
        step(2'b00, 1'b1, 1'b0, 1'b0);
        step(2'b00, 1'b1, 1'b0, 1'b1);
        step(2'b00, 1'b0, 1'b0, 1'b0);
        check("R8", rd_oe, '0);
        // Random mix of bursts
        for (int n = 0; n < 3000; n++) begin
            logic [LANES-1:0] m;
            logic r, w;
            int   k;
            m = LANES'($urandom);
            k = int'($urandom_range(0, 9));
            r = (k < 5);
            w = (k >= 4 && k < 7);
            step(m, r, w, ($urandom_range(0, 199) == 0));
        end
        finish_run();
    end

endmodule